// File: doc/BRIEF.md
# Interrupt Vector Ring Producer

This block collects interrupt events raised by on-chip sources and stores each one as a four-dword record in a circular buffer that lives in system memory. The host drains the buffer at its own pace. The producer owns the write position, and the host owns the read position, which it programs through a small register port. Whenever the two positions differ and the ring is switched on, the block holds its interrupt line high.

A source presents an event on a valid/ready handshake. The block then spends four cycles on a plain dword write port, storing the record at ascending addresses. After the fourth write it advances its write position by 16 bytes, wrapped to the programmed ring size. Optionally it then makes one more write that copies the new write-position register to a memory word the host can poll. If the ring is already full when an event is accepted, the record still goes in and overwrites the oldest slot, and a sticky overflow flag inside the write-position register is raised. Software clears that flag through a dedicated control bit.

Top module: `ivRingProducer`

## Requirements
- R1: After reset, evtReady, irqOut and memWrEn are low and every register reads back as zero.
- R2: An event is accepted only when both the ring-enable bit (CTRL bit 0) and the interrupt-enable bit (CTRL bit 1) are set and the block is idle. Otherwise evtReady stays low and no memory write occurs.
- R3: An accepted event produces four memory writes on consecutive cycles, starting the cycle after acceptance. The addresses are B+W, B+W+4, B+W+8 and B+W+12, where B is the BASE register shifted left by 8 (a 40-bit address) and W is the write pointer. Record layout: word 0 carries the source id in bits [7:0]. Word 1 carries the 28-bit source data in bits [27:0]. Word 2 carries the ring id in [7:0], the vmid in [15:8] and the pasid in [31:16]. Word 3 is zero. All unused bits are zero.
- R4: The write pointer counts bytes. It advances by 16 on the cycle after the fourth write and wraps with mask 2^(S+2)-1, where S is CTRL bits [8:4], the log2 of the ring size in dwords.
- R5: irqOut is high exactly when the ring and interrupt enables are both set and the read pointer differs from the write pointer.
- R6: If ((W+16) & mask) equals the read pointer when an event is accepted, the record is still written and bit 0 of the WPTR register (the overflow flag) becomes 1 when the pointer advances.
- R7: The overflow flag stays set until a CTRL write with bit 3 set. A CTRL write with bit 3 clear leaves it unchanged, and bit 3 reads back as zero.
- R8: When CTRL bit 2 (writeback enable) is set, each pointer advance is followed by one extra write, one cycle after the fourth record write. Its address is {WBHI[7:0], WBLO[31:2], 2'b00} and its data equals the updated WPTR register value. When bit 2 is clear, no extra write occurs.
- R9: evtReady is low from the cycle after acceptance until the last write of that event (record or writeback) has issued, and high again on the following cycle.
- R10: Register offsets are CTRL=0, BASE=1, RPTR=2, WPTR=3, WBLO=4 and WBHI=5. WBHI keeps only 8 bits. Written pointers drop their low 4 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evtValid | input | 1 | Event offered |
| evtReady | output | 1 | Event can be taken this cycle |
| evtSrcId | input | 8 | Source id |
| evtSrcData | input | 28 | Source data |
| evtRingId | input | 8 | Ring id |
| evtVmid | input | 8 | Virtual machine id |
| evtPasid | input | 16 | Process address space id |
| memWrEn | output | 1 | Dword write strobe |
| memAddr | output | 40 | Byte address of the dword |
| memData | output | 32 | Dword data |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| irqOut | output | 1 | Unread records present |

## Verification
The hardest condition to reach from the ports is an event accepted while the ring is full, because the producer has to lap the host. The stimulus gets there by programming a tiny ring of four slots, leaving the read pointer at zero and pushing events from a table until the fourth one lands on the full slot. A second ring of two slots repeats the case across a wrap. Clearing the flag with and without the clear bit, and running with writeback on and off, then shows that the flag is sticky and that the writeback copy carries the flag.

// File: rtl/ivring_pkg.sv
package ivring_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DW0, ST_DW1, ST_DW2, ST_DW3, ST_WBK
  } ivState_e;

  typedef struct packed {
    logic       take;     // event latched this cycle
    logic       wrVec;    // a record dword is on the port
    logic [1:0] dwSel;    // which record dword
    logic       advance;  // bump write pointer at end of cycle
    logic       wrBack;   // writeback dword is on the port
  } ctrlStrobe_t;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_BASE = 3'd1;
  localparam logic [2:0] REG_RPTR = 3'd2;
  localparam logic [2:0] REG_WPTR = 3'd3;
  localparam logic [2:0] REG_WBLO = 3'd4;
  localparam logic [2:0] REG_WBHI = 3'd5;

  localparam int CTL_RING_EN = 0;
  localparam int CTL_INTR_EN = 1;
  localparam int CTL_WB_EN   = 2;
  localparam int CTL_OVF_CLR = 3;
  localparam int CTL_SIZE_LO = 4;
  localparam int SIZE_W      = 5;

  localparam int VEC_BYTES   = 16;
  localparam int ADDR_W      = 40;

endpackage

// File: rtl/ivring_ctrl.sv
module ivring_ctrl
  import ivring_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        enabled,
  input  logic        wbEn,
  input  logic        evtValid,
  output logic        evtReady,
  output ctrlStrobe_t strobe
);

  ivState_e state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    evtReady  = enabled && (state == ST_IDLE);
    unique case (state)
      ST_IDLE: begin
        if (evtValid && evtReady) begin
          strobe.take = 1'b1;
          nextState   = ST_DW0;
        end
      end
      ST_DW0: begin
        strobe.wrVec = 1'b1;
        strobe.dwSel = 2'd0;
        nextState    = ST_DW1;
      end
      ST_DW1: begin
        strobe.wrVec = 1'b1;
        strobe.dwSel = 2'd1;
        nextState    = ST_DW2;
      end
      ST_DW2: begin
        strobe.wrVec = 1'b1;
        strobe.dwSel = 2'd2;
        nextState    = ST_DW3;
      end
      ST_DW3: begin
        strobe.wrVec   = 1'b1;
        strobe.dwSel   = 2'd3;
        strobe.advance = 1'b1;
        nextState      = wbEn ? ST_WBK : ST_IDLE;
      end
      ST_WBK: begin
        strobe.wrBack = 1'b1;
        nextState     = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // R3: acceptance is followed by the first record dword
  assert_accept_first_dword_R3: assert property (@(posedge clk) disable iff (rst)
    (evtValid && evtReady) |=> (strobe.wrVec && strobe.dwSel == 2'd0));

  // R3: record dwords follow one another in ascending order
  assert_dword_order_R3: assert property (@(posedge clk) disable iff (rst)
    (strobe.wrVec && strobe.dwSel != 2'd3) |=>
      (strobe.wrVec && strobe.dwSel == $past(strobe.dwSel) + 2'd1));

  // R9: no acceptance while the port is busy
  assert_ready_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (strobe.wrVec || strobe.wrBack) |-> !evtReady);

endmodule

// File: rtl/ivring_dpath.sv
module ivring_dpath
  import ivring_pkg::*;
#(
  parameter int PTR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic [7:0]        evtSrcId,
  input  logic [27:0]       evtSrcData,
  input  logic [7:0]        evtRingId,
  input  logic [7:0]        evtVmid,
  input  logic [15:0]       evtPasid,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              enabled,
  output logic              wbEn,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memData,
  output logic              irqOut
);

  localparam logic [PTR_W-1:0] PTR_STEP  = PTR_W'(VEC_BYTES);
  localparam logic [PTR_W-1:0] PTR_ALIGN = ~PTR_W'(VEC_BYTES - 1);

  // configuration
  logic              ringEn, intrEn;
  logic [SIZE_W-1:0] sizeLog2;
  logic [31:0]       baseReg;
  logic [31:0]       wbLo;
  logic [7:0]        wbHi;
  // pointers and status
  logic [PTR_W-1:0]  rdPtr, wrPtr, ptrMask, wrPtrNext;
  logic              ovfFlag, fullLat;
  // latched event
  logic [7:0]        latSrcId, latRingId, latVmid;
  logic [27:0]       latSrcData;
  logic [15:0]       latPasid;

  logic [5:0]        byteLog;
  logic              ctrlWr, wptrWr, ovfClr;
  logic [31:0]       wptrView;
  logic [ADDR_W-1:0] ringBase, wbAddr;

  assign ctrlWr = regWrEn && (regAddr == REG_CTRL);
  assign wptrWr = regWrEn && (regAddr == REG_WPTR);
  assign ovfClr = ctrlWr && regWrData[CTL_OVF_CLR];

  always_comb begin
    byteLog = 6'(sizeLog2) + 6'd2;
    if (int'(byteLog) >= PTR_W) ptrMask = '1;
    else                        ptrMask = ~({PTR_W{1'b1}} << byteLog);
  end

  assign wrPtrNext = (wrPtr + PTR_STEP) & ptrMask;
  assign enabled   = ringEn && intrEn;
  assign irqOut    = enabled && (rdPtr != wrPtr);
  assign wptrView  = 32'(wrPtr) | {31'd0, ovfFlag};
  assign ringBase  = {baseReg, 8'h00};
  assign wbAddr    = {wbHi, wbLo[31:2], 2'b00};

  // register file
  always_ff @(posedge clk) begin
    if (rst) begin
      ringEn   <= 1'b0;
      intrEn   <= 1'b0;
      wbEn     <= 1'b0;
      sizeLog2 <= '0;
      baseReg  <= '0;
      rdPtr    <= '0;
      wbLo     <= '0;
      wbHi     <= '0;
    end else if (regWrEn) begin
      unique case (regAddr)
        REG_CTRL: begin
          ringEn   <= regWrData[CTL_RING_EN];
          intrEn   <= regWrData[CTL_INTR_EN];
          wbEn     <= regWrData[CTL_WB_EN];
          sizeLog2 <= regWrData[CTL_SIZE_LO +: SIZE_W];
        end
        REG_BASE: baseReg <= regWrData;
        REG_RPTR: rdPtr   <= regWrData[PTR_W-1:0] & PTR_ALIGN;
        REG_WBLO: wbLo    <= regWrData;
        REG_WBHI: wbHi    <= regWrData[7:0];
        default: ;
      endcase
    end
  end

  // write pointer and sticky overflow
  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr   <= '0;
      ovfFlag <= 1'b0;
    end else begin
      if (wptrWr)              wrPtr <= regWrData[PTR_W-1:0] & PTR_ALIGN;
      else if (strobe.advance) wrPtr <= wrPtrNext;
      if (strobe.advance && fullLat) ovfFlag <= 1'b1;
      else if (ovfClr)               ovfFlag <= 1'b0;
    end
  end

  // event capture with full detection at acceptance
  always_ff @(posedge clk) begin
    if (rst) begin
      latSrcId   <= '0;
      latSrcData <= '0;
      latRingId  <= '0;
      latVmid    <= '0;
      latPasid   <= '0;
      fullLat    <= 1'b0;
    end else if (strobe.take) begin
      latSrcId   <= evtSrcId;
      latSrcData <= evtSrcData;
      latRingId  <= evtRingId;
      latVmid    <= evtVmid;
      latPasid   <= evtPasid;
      fullLat    <= (wrPtrNext == rdPtr);
    end
  end

  // memory write port
  always_comb begin
    memWrEn = strobe.wrVec || strobe.wrBack;
    memAddr = '0;
    memData = '0;
    if (strobe.wrVec) begin
      memAddr = ringBase + ADDR_W'(wrPtr) + ADDR_W'({strobe.dwSel, 2'b00});
      unique case (strobe.dwSel)
        2'd0: memData = {24'd0, latSrcId};
        2'd1: memData = {4'd0, latSrcData};
        2'd2: memData = {latPasid, latVmid, latRingId};
        default: memData = '0;
      endcase
    end else if (strobe.wrBack) begin
      memAddr = wbAddr;
      memData = wptrView;
    end
  end

  // register read
  always_comb begin
    unique case (regAddr)
      REG_CTRL: regRdData = 32'({sizeLog2, 1'b0, wbEn, intrEn, ringEn});
      REG_BASE: regRdData = baseReg;
      REG_RPTR: regRdData = 32'(rdPtr);
      REG_WPTR: regRdData = wptrView;
      REG_WBLO: regRdData = wbLo;
      REG_WBHI: regRdData = {24'd0, wbHi};
      default:  regRdData = '0;
    endcase
  end

  // R4: pointer steps by one record, wrapped, and only on advance
  assert_wptr_step_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(strobe.advance) && !$past(wptrWr)) |->
      (wrPtr == (($past(wrPtr) + PTR_STEP) & $past(ptrMask))));

  assert_wptr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(strobe.advance) && !$past(wptrWr)) |-> $stable(wrPtr));

  // R7: overflow flag is sticky unless cleared
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(ovfFlag) && !$past(regWrEn && regAddr == REG_CTRL && regWrData[CTL_OVF_CLR]))
      |-> ovfFlag);

  // R3: first record dword lands at base plus write pointer
  assert_first_addr_R3: assert property (@(posedge clk) disable iff (rst)
    $past(strobe.take) |-> (memWrEn && memAddr == ringBase + ADDR_W'(wrPtr)));

  // R8: writeback copies the updated pointer register
  assert_wb_data_R8: assert property (@(posedge clk) disable iff (rst)
    strobe.wrBack |-> (memData[PTR_W-1:1] == wrPtr[PTR_W-1:1] && memData[0] == ovfFlag));

endmodule

// File: rtl/ivRingProducer.sv
module ivRingProducer
  import ivring_pkg::*;
#(
  parameter int PTR_W = 18
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        evtValid,
  output logic        evtReady,
  input  logic [7:0]  evtSrcId,
  input  logic [27:0] evtSrcData,
  input  logic [7:0]  evtRingId,
  input  logic [7:0]  evtVmid,
  input  logic [15:0] evtPasid,
  output logic        memWrEn,
  output logic [39:0] memAddr,
  output logic [31:0] memData,
  input  logic        regWrEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        irqOut
);

  ctrlStrobe_t strobe;
  logic        enabled, wbEn;

  ivring_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .enabled  (enabled),
    .wbEn     (wbEn),
    .evtValid (evtValid),
    .evtReady (evtReady),
    .strobe   (strobe)
  );

  ivring_dpath #(.PTR_W(PTR_W)) dpath_i (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .evtSrcId   (evtSrcId),
    .evtSrcData (evtSrcData),
    .evtRingId  (evtRingId),
    .evtVmid    (evtVmid),
    .evtPasid   (evtPasid),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .enabled    (enabled),
    .wbEn       (wbEn),
    .memWrEn    (memWrEn),
    .memAddr    (memAddr),
    .memData    (memData),
    .irqOut     (irqOut)
  );

endmodule

// File: tb/ivRingProducer_tb.sv
module ivRingProducer_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0]  srcId;
    logic [27:0] srcData;
    logic [7:0]  ringId;
    logic [7:0]  vmid;
    logic [15:0] pasid;
  } evt_t;

  localparam int N_EVT = 6;
  localparam evt_t EVT_TABLE [N_EVT] = '{
    '{8'h11, 28'h0123456, 8'h01, 8'h02, 16'hBEEF},
    '{8'hFF, 28'hFFFFFFF, 8'hFF, 8'hFF, 16'hFFFF},
    '{8'h00, 28'h0000000, 8'h00, 8'h00, 16'h0000},
    '{8'hA5, 28'h5A5A5A5, 8'h3C, 8'hC3, 16'h1234},  // lands on full slot
    '{8'h42, 28'h8000001, 8'h80, 8'h01, 16'h8001},
    '{8'h7E, 28'h0FEDCBA, 8'h10, 8'h20, 16'h3040}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evtValid = 1'b0;
  logic        evtReady;
  logic [7:0]  evtSrcId = '0;
  logic [27:0] evtSrcData = '0;
  logic [7:0]  evtRingId = '0;
  logic [7:0]  evtVmid = '0;
  logic [15:0] evtPasid = '0;
  logic        memWrEn;
  logic [39:0] memAddr;
  logic [31:0] memData;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;

  int nChecks = 0;
  int nErrors = 0;

  logic [39:0] logA[$];
  logic [31:0] logD[$];

  // reference model state
  logic [17:0] mWptr, mRptr, mMask;
  logic        mOvf, mWb;
  logic [39:0] mBase, mWbAddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  ivRingProducer dut_i (
    .clk(clk), .rst(rst),
    .evtValid(evtValid), .evtReady(evtReady),
    .evtSrcId(evtSrcId), .evtSrcData(evtSrcData), .evtRingId(evtRingId),
    .evtVmid(evtVmid), .evtPasid(evtPasid),
    .memWrEn(memWrEn), .memAddr(memAddr), .memData(memData),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  always @(posedge clk) begin
    if (!rst && memWrEn) begin
      logA.push_back(memAddr);
      logD.push_back(memData);
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic sendEvt(input evt_t e);
    @(negedge clk);
    evtSrcId = e.srcId; evtSrcData = e.srcData; evtRingId = e.ringId;
    evtVmid = e.vmid; evtPasid = e.pasid; evtValid = 1'b1;
    while (!evtReady) @(negedge clk);
    @(negedge clk);
    evtValid = 1'b0;
    chk("R9 ready low while writing", 64'(evtReady), 64'd0);
    repeat (6) @(negedge clk);
    chk("R9 ready back after writes", 64'(evtReady), 64'd1);
  endtask

  // push one event and check its record, pointer, writeback and irq
  task automatic runEvt(input evt_t e);
    int          start;
    logic        full;
    logic [39:0] vecA;
    logic [31:0] rd;
    logic [31:0] expD [4];
    start = logA.size();
    full  = (((mWptr + 18'd16) & mMask) == mRptr);
    vecA  = mBase + 40'(mWptr);
    expD[0] = {24'd0, e.srcId};
    expD[1] = {4'd0, e.srcData};
    expD[2] = {e.pasid, e.vmid, e.ringId};
    expD[3] = 32'd0;
    sendEvt(e);
    mWptr = (mWptr + 18'd16) & mMask;
    if (full) mOvf = 1'b1;
    chk("R3/R8 write count", 64'(logA.size() - start), mWb ? 64'd5 : 64'd4);
    if (logA.size() - start >= 4) begin
      for (int k = 0; k < 4; k++) begin
        chk("R3 record address", 64'(logA[start+k]), 64'(vecA + 40'(4*k)));
        chk("R3 record data", 64'(logD[start+k]), 64'(expD[k]));
      end
    end
    regRd(3'd3, rd);
    chk("R4/R6 WPTR register", 64'(rd), 64'(32'(mWptr) | {31'd0, mOvf}));
    if (mWb && logA.size() - start == 5) begin
      chk("R8 writeback address", 64'(logA[start+4]), 64'(mWbAddr));
      chk("R8 writeback data", 64'(logD[start+4]), 64'(32'(mWptr) | {31'd0, mOvf}));
    end
    chk("R5 irq level", 64'(irqOut), 64'(mWptr != mRptr));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int          cnt;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ready after reset", 64'(evtReady), 64'd0);
    chk("R1 irq after reset", 64'(irqOut), 64'd0);
    chk("R1 memWrEn after reset", 64'(memWrEn), 64'd0);
    rst = 1'b0;
    for (int a = 0; a < 6; a++) begin
      regRd(3'(a), rd);
      chk("R1 register reset value", 64'(rd), 64'd0);
    end

    // R2: ring enable alone does not open the input
    regWr(3'd0, 32'h1);
    @(negedge clk);
    evtValid = 1'b1;
    cnt = logA.size();
    repeat (5) @(negedge clk);
    chk("R2 ready low without intr enable", 64'(evtReady), 64'd0);
    evtValid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 no write while disabled", 64'(logA.size() - cnt), 64'd0);
    regRd(3'd3, rd);
    chk("R2 pointer untouched", 64'(rd), 64'd0);

    // R10: configuration and readback; 16-dword ring = four records
    regWr(3'd1, 32'h00ABCD01);
    regWr(3'd4, 32'h00001003);
    regWr(3'd5, 32'h000001F5);
    regWr(3'd2, 32'h0);
    regWr(3'd0, 32'h0000004F);  // size 4, wb, intr, ring, plus clear bit
    regRd(3'd0, rd); chk("R10 R7 CTRL readback, clear bit reads 0", 64'(rd), 64'h47);
    regRd(3'd1, rd); chk("R10 BASE readback", 64'(rd), 64'h00ABCD01);
    regRd(3'd4, rd); chk("R10 WBLO readback", 64'(rd), 64'h00001003);
    regRd(3'd5, rd); chk("R10 WBHI keeps 8 bits", 64'(rd), 64'hF5);
    mBase = 40'h00ABCD0100; mWbAddr = 40'hF500001000;
    mWptr = '0; mRptr = '0; mMask = 18'd63; mOvf = 1'b0; mWb = 1'b1;

    // table walk: fourth event hits the full ring (R6)
    for (int i = 0; i < N_EVT; i++) runEvt(EVT_TABLE[i]);

    // R7: writing CTRL without the clear bit keeps overflow
    regWr(3'd0, 32'h00000047);
    regRd(3'd3, rd); chk("R7 overflow sticky", 64'(rd[0]), 64'd1);
    regWr(3'd0, 32'h0000004F);
    mOvf = 1'b0;
    regRd(3'd3, rd); chk("R7 overflow cleared", 64'(rd), 64'(32'(mWptr)));

    // R5: host read pointer controls the interrupt
    regWr(3'd2, 32'(mWptr));
    mRptr = mWptr;
    @(negedge clk); chk("R5 irq low when caught up", 64'(irqOut), 64'd0);
    regWr(3'd2, 32'h10);
    mRptr = 18'h10;
    @(negedge clk); chk("R5 irq high with unread data", 64'(irqOut), 64'd1);

    // R8: writeback off yields exactly four writes
    regWr(3'd0, 32'h00000043);
    mWb = 1'b0;
    runEvt(EVT_TABLE[0]);

    // R4/R6: two-slot ring wraps and overflows
    regWr(3'd0, 32'h0);
    regWr(3'd3, 32'h0);
    regWr(3'd2, 32'h0);
    regWr(3'd0, 32'h0000003B);  // size 3, intr, ring, clear
    mWptr = '0; mRptr = '0; mMask = 18'd31; mOvf = 1'b0; mWb = 1'b0;
    runEvt(EVT_TABLE[1]);
    runEvt(EVT_TABLE[3]);
    regRd(3'd3, rd); chk("R4 R6 wrap to zero with overflow", 64'(rd), 64'h1);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule